// File: doc/BRIEF.md
# Fine-Grained Translation Invalidate Decoder and Trap Gate

This block looks at one 32-bit instruction word per cycle and picks out the five instructions that split a translation-cache flush into separate pieces. Three of them invalidate entries: a supervisor invalidate and two hypervisor invalidates, one for guest-virtual and one for guest-physical addresses. Two of them only order memory accesses: one before a batch of invalidates and one after it. For each word it recognises, the block reports which operation it is and passes on the two source register indices. It also decides from the hart's privilege state whether the instruction may proceed, must raise an illegal-instruction exception, or must raise a virtual-instruction exception.

A decode stage drives the word together with a valid strobe and the current privilege level, virtualisation bit, trap-on-translation bits and a strap that enables the hypervisor. All results come out of a register one cycle later. Words outside the group produce no operation and no exception, so other decoders can handle them. Executing the invalidations is left to other logic.

Top module: `inv_decode_gate`

## Requirements
- R1: While reset is held low at a clock edge, every output is 0 after that edge.
- R2: Outputs follow the inputs of the previous clock edge. `out_valid` equals the previous `in_valid`. When the previous `in_valid` was 0, all other outputs are 0.
- R3: For a valid word, `out_rs1` is word bits [19:15] and `out_rs2` is word bits [24:20], whether or not the word is recognised.
- R4: A word belongs to the group when bits [6:0] are 1110011, bits [14:12] are 000 and bits [31:25] are one of 0001011, 0001100, 0010011 or 0110011. A well-formed word sets exactly one bit of `op_onehot`: bit 0 for the supervisor invalidate (0001011), bit 1 for the pre-fence, bit 2 for the post-fence, bit 3 for the guest-virtual invalidate (0010011) and bit 4 for the guest-physical invalidate (0110011). A word outside the group gives `op_onehot` = 0 and no exception.
- R5: Funct7 0001100 with rs1 = 0 selects the pre-fence when rs2 = 0 and the post-fence when rs2 = 1. Any other rs1 or rs2 value with this funct7 gives `op_onehot` = 0 and `exc_illegal` = 1.
- R6: A group word whose bits [11:7] are non-zero gives `op_onehot` = 0 and `exc_illegal` = 1.
- R7: With `hyp_en` = 0, the two hypervisor invalidate encodings give `op_onehot` = 0 and `exc_illegal` = 1, and `virt_mode` has no effect.
- R8: In user mode (`priv_lvl` 00, and the unused code 10 is treated the same way), every recognised operation raises `exc_illegal`.
- R9: In machine mode (`priv_lvl` 11), no well-formed operation raises any exception.
- R10: In supervisor mode (`priv_lvl` 01), the supervisor invalidate raises `exc_illegal` when V = 0 and `tvm` = 1. It raises `exc_virtual` when V = 1 and `vtvm` = 1. In all other cases it raises nothing.
- R11: In supervisor mode with V = 0, the guest-physical invalidate raises `exc_illegal` when `tvm` = 1 and nothing otherwise, and the guest-virtual invalidate raises nothing. With V = 1 (and `hyp_en` = 1), both hypervisor invalidates raise `exc_virtual`.
- R12: In supervisor mode the two fences never raise an exception, whatever the values of `tvm`, `vtvm` and V.
- R13: At most one bit of `op_onehot` is set, and `exc_illegal` and `exc_virtual` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction word is present |
| in_word | input | 32 | Instruction word |
| priv_lvl | input | 2 | Privilege: 00 user, 01 supervisor, 11 machine (10 is treated as user) |
| virt_mode | input | 1 | Hart is running virtualised (V) |
| tvm | input | 1 | Trap translation management in supervisor mode |
| vtvm | input | 1 | Trap translation management in virtual supervisor mode |
| hyp_en | input | 1 | Hypervisor support is enabled |
| out_valid | output | 1 | Registered copy of `in_valid` |
| op_onehot | output | 5 | Recognised operation, one-hot (0 = none) |
| out_rs1 | output | 5 | Address register index |
| out_rs2 | output | 5 | ASID/VMID register index (fence selector for the fences) |
| exc_illegal | output | 1 | Illegal-instruction exception |
| exc_virtual | output | 1 | Virtual-instruction exception |

## Verification
The hardest cases to reach are the ones where a valid encoding meets exactly the right privilege state. Examples are the supervisor invalidate in virtual supervisor mode with only `vtvm` set, and the guest-physical invalidate with `tvm` set and V clear. With uniformly random words these almost never line up. The stimulus therefore builds words field by field, favours the group's funct7 codes and the zero rd, rs1 and fence-selector values, and draws the privilege and control bits on their own. Directed cases then walk through every operation against every privilege and trap-bit setting the trap requirements name, including the malformed fence and disabled-hypervisor encodings.

// File: rtl/invq_pkg.sv
// Package: shared encodings, operation indices and the instruction field
// layout used by the fine-grained invalidate decoder.
package invq_pkg;

    localparam int NUM_OPS   = 5;
    localparam int IDX_W     = 5;
    localparam int WORD_W    = 32;

    // operation positions in the one-hot result
    localparam int OP_SINV   = 0;
    localparam int OP_WFENCE = 1;
    localparam int OP_RFENCE = 2;
    localparam int OP_HVVMA  = 3;
    localparam int OP_HGVMA  = 4;

    localparam logic [6:0] OPC_SYSTEM = 7'b1110011;
    localparam logic [2:0] F3_PRIV    = 3'b000;
    localparam logic [6:0] F7_SINV    = 7'b0001011;
    localparam logic [6:0] F7_FENCE   = 7'b0001100;
    localparam logic [6:0] F7_HVVMA   = 7'b0010011;
    localparam logic [6:0] F7_HGVMA   = 7'b0110011;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'b00,
        PRIV_SUPER = 2'b01,
        PRIV_RSVD  = 2'b10,
        PRIV_MACH  = 2'b11
    } priv_t;

    typedef struct packed {
        logic [6:0]       f7;
        logic [IDX_W-1:0] rs2;
        logic [IDX_W-1:0] rs1;
        logic [2:0]       f3;
        logic [IDX_W-1:0] rd;
        logic [6:0]       opc;
    } rtype_t;

    // funct7 code expected for each operation slot
    function automatic logic [6:0] op_f7(input int idx);
        case (idx)
            OP_SINV:   op_f7 = F7_SINV;
            OP_WFENCE: op_f7 = F7_FENCE;
            OP_RFENCE: op_f7 = F7_FENCE;
            OP_HVVMA:  op_f7 = F7_HVVMA;
            default:   op_f7 = F7_HGVMA;
        endcase
    endfunction

    // hypervisor invalidates need the hypervisor strap
    function automatic logic op_needs_hyp(input int idx);
        op_needs_hyp = (idx == OP_HVVMA) || (idx == OP_HGVMA);
    endfunction

    // fences demand rs1 = 0 and a fixed rs2 selector
    function automatic logic op_is_fence(input int idx);
        op_is_fence = (idx == OP_WFENCE) || (idx == OP_RFENCE);
    endfunction

    function automatic logic [IDX_W-1:0] op_fence_sel(input int idx);
        op_fence_sel = (idx == OP_RFENCE) ? IDX_W'(1) : IDX_W'(0);
    endfunction

endpackage

// File: rtl/inv_field_split.sv
// inv_field_split: cuts a 32-bit word into its register-type fields.
// Assumes the word is already aligned; purely combinational.
module inv_field_split
    import invq_pkg::*;
#(
    parameter int WORD_BITS = WORD_W
) (
    input  logic [WORD_BITS-1:0] word,
    output rtype_t               fields
);
    // reinterpret the word as the packed field struct
    always_comb begin
        fields = rtype_t'(word[$bits(rtype_t)-1:0]);
    end
endmodule

// File: rtl/inv_op_match.sv
// inv_op_match: finds which operation of the group a word encodes.
// Produces a one-hot hit vector for well-formed words and a malformed flag
// for words inside the group that break a form rule or need the hypervisor
// while it is disabled. Words outside the group give neither.
module inv_op_match
    import invq_pkg::*;
#(
    parameter int OPS = NUM_OPS
) (
    input  rtype_t         fields,
    input  logic           hyp_en,
    output logic [OPS-1:0] op_hit,
    output logic           malformed
);
    logic           base_ok;
    logic [OPS-1:0] fam_hit;
    logic           group_hit;

    // opcode and funct3 common to the whole group
    always_comb begin
        base_ok = (fields.opc == OPC_SYSTEM) && (fields.f3 == F3_PRIV);
    end

    // one matcher per operation slot
    for (genvar gi = 0; gi < OPS; gi++) begin : g_slot
        logic form_ok;
        // form rule: fences fix rs1 and rs2, others leave them free
        always_comb begin
            if (op_is_fence(gi)) begin
                form_ok = (fields.rs1 == '0) && (fields.rs2 == op_fence_sel(gi));
            end else begin
                form_ok = 1'b1;
            end
        end
        // family match and the final well-formed hit for this slot
        always_comb begin
            fam_hit[gi] = base_ok && (fields.f7 == op_f7(gi));
            op_hit[gi]  = fam_hit[gi] && form_ok && (fields.rd == '0)
                          && (hyp_en || !op_needs_hyp(gi));
        end
    end

    // group word that produced no hit is malformed
    always_comb begin
        group_hit = |fam_hit;
        malformed = group_hit && (op_hit == '0);
    end
endmodule

// File: rtl/inv_trap_rules.sv
// inv_trap_rules: applies the privilege and trap-bit rules to a decoded
// operation. Assumes op_hit is one-hot or zero. The virtualisation bit only
// counts when the hypervisor is enabled and the hart is in supervisor mode.
// Illegal takes precedence, so at most one exception is raised.
module inv_trap_rules
    import invq_pkg::*;
#(
    parameter int OPS = NUM_OPS
) (
    input  logic [OPS-1:0] op_hit,
    input  logic           malformed,
    input  logic [1:0]     priv_lvl,
    input  logic           virt_mode,
    input  logic           hyp_en,
    input  logic           tvm,
    input  logic           vtvm,
    output logic           want_illegal,
    output logic           want_virtual
);
    logic any_op;
    logic in_user;
    logic in_hs;
    logic in_vs;
    logic ill_by_tvm;
    logic virt_hit;

    // classify the privilege state
    always_comb begin
        any_op  = |op_hit;
        in_user = (priv_lvl == PRIV_USER) || (priv_lvl == PRIV_RSVD);
        in_hs   = (priv_lvl == PRIV_SUPER) && !(virt_mode && hyp_en);
        in_vs   = (priv_lvl == PRIV_SUPER) && virt_mode && hyp_en;
    end

    // illegal-instruction sources for well-formed operations
    always_comb begin
        ill_by_tvm = in_hs && tvm && (op_hit[OP_SINV] || op_hit[OP_HGVMA]);
    end

    // virtual-instruction sources
    always_comb begin
        virt_hit = in_vs && ((op_hit[OP_SINV] && vtvm)
                             || op_hit[OP_HVVMA] || op_hit[OP_HGVMA]);
    end

    // combine with illegal taking priority
    always_comb begin
        want_illegal = malformed || (any_op && in_user) || ill_by_tvm;
        want_virtual = !want_illegal && virt_hit;
    end
endmodule

// File: rtl/inv_decode_gate.sv
// inv_decode_gate: top of the fine-grained invalidate decoder. It decodes
// one word per cycle and registers the operation, the source indices and
// the exception decision with one cycle of latency. Assumes a synchronous
// active-low reset. Outputs are zero in cycles without a valid word.
module inv_decode_gate
    import invq_pkg::*;
#(
    parameter int WORD_BITS = WORD_W,
    parameter int OPS       = NUM_OPS,
    parameter int RIDX_W    = IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [WORD_BITS-1:0] in_word,
    input  logic [1:0]           priv_lvl,
    input  logic                 virt_mode,
    input  logic                 tvm,
    input  logic                 vtvm,
    input  logic                 hyp_en,
    output logic                 out_valid,
    output logic [OPS-1:0]       op_onehot,
    output logic [RIDX_W-1:0]    out_rs1,
    output logic [RIDX_W-1:0]    out_rs2,
    output logic                 exc_illegal,
    output logic                 exc_virtual
);
    rtype_t         fields;
    logic [OPS-1:0] op_hit;
    logic           malformed;
    logic           want_illegal;
    logic           want_virtual;

    inv_field_split #(.WORD_BITS(WORD_BITS)) u_split (
        .word   (in_word),
        .fields (fields)
    );

    inv_op_match #(.OPS(OPS)) u_match (
        .fields    (fields),
        .hyp_en    (hyp_en),
        .op_hit    (op_hit),
        .malformed (malformed)
    );

    inv_trap_rules #(.OPS(OPS)) u_trap (
        .op_hit       (op_hit),
        .malformed    (malformed),
        .priv_lvl     (priv_lvl),
        .virt_mode    (virt_mode),
        .hyp_en       (hyp_en),
        .tvm          (tvm),
        .vtvm         (vtvm),
        .want_illegal (want_illegal),
        .want_virtual (want_virtual)
    );

    // output register: capture decision on valid, clear otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            out_valid   <= 1'b0;
            op_onehot   <= '0;
            out_rs1     <= '0;
            out_rs2     <= '0;
            exc_illegal <= 1'b0;
            exc_virtual <= 1'b0;
        end else begin
            out_valid   <= 1'b1;
            op_onehot   <= op_hit;
            out_rs1     <= RIDX_W'(fields.rs1);
            out_rs2     <= RIDX_W'(fields.rs2);
            exc_illegal <= want_illegal;
            exc_virtual <= want_virtual;
        end
    end
endmodule

// File: rtl/inv_decode_gate_chk.sv
// inv_decode_gate_chk: property checker bound to inv_decode_gate. It
// relates the registered outputs to the inputs of the previous cycle.
module inv_decode_gate_chk
    import invq_pkg::*;
#(
    parameter int OPS = NUM_OPS
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [1:0]     priv_lvl,
    input logic           out_valid,
    input logic [OPS-1:0] op_onehot,
    input logic           exc_illegal,
    input logic           exc_virtual
);
    a_r13_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_onehot));

    a_r13_one_exc: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_illegal && exc_virtual));

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (out_valid == $past(in_valid)));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (op_onehot == '0 && !exc_illegal && !exc_virtual));

    a_r12_fence_free: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && (op_onehot[OP_WFENCE] || op_onehot[OP_RFENCE])
        && $past(priv_lvl) == PRIV_SUPER |-> !exc_illegal && !exc_virtual);

    a_r9_mach_free: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && (op_onehot != '0) && $past(priv_lvl) == PRIV_MACH
        |-> !exc_illegal && !exc_virtual);

    a_r8_user_ill: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && (op_onehot != '0) && !$past(priv_lvl[0]) |-> exc_illegal);
endmodule

bind inv_decode_gate inv_decode_gate_chk #(.OPS(OPS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .priv_lvl    (priv_lvl),
    .out_valid   (out_valid),
    .op_onehot   (op_onehot),
    .exc_illegal (exc_illegal),
    .exc_virtual (exc_virtual)
);

// File: tb/tb_inv_decode_gate.sv
// Bench for inv_decode_gate: directed corners plus seeded random words,
// compared with a reference model written from the requirements.
module tb_inv_decode_gate;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic [1:0]  priv_lvl = 2'b00;
    logic        virt_mode = 1'b0;
    logic        tvm = 1'b0;
    logic        vtvm = 1'b0;
    logic        hyp_en = 1'b0;
    logic        out_valid;
    logic [4:0]  op_onehot;
    logic [4:0]  out_rs1;
    logic [4:0]  out_rs2;
    logic        exc_illegal;
    logic        exc_virtual;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    inv_decode_gate dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .priv_lvl(priv_lvl), .virt_mode(virt_mode), .tvm(tvm), .vtvm(vtvm),
        .hyp_en(hyp_en), .out_valid(out_valid), .op_onehot(op_onehot),
        .out_rs1(out_rs1), .out_rs2(out_rs2), .exc_illegal(exc_illegal),
        .exc_virtual(exc_virtual)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] rs2,
                                       input logic [4:0] rs1, input logic [4:0] rd);
        mk = {f7, rs2, rs1, 3'b000, rd, 7'b1110011};
    endfunction

    // reference: returns {onehot[4:0], ill, virt}
    function automatic logic [6:0] ref_model(input logic [31:0] w, input logic [1:0] p,
                                             input logic v, input logic t, input logic vt,
                                             input logic h);
        logic [4:0] oh;
        logic bad, ill, vir, grp, usr, sup, vv;
        oh = '0; bad = 0; ill = 0; vir = 0;
        grp = (w[6:0] == 7'b1110011) && (w[14:12] == 3'b000) &&
              (w[31:25] inside {7'b0001011, 7'b0001100, 7'b0010011, 7'b0110011});
        if (grp) begin
            if (w[11:7] != 0) bad = 1;                          // R6
            else if (w[31:25] == 7'b0001100) begin              // R5
                if (w[19:15] == 0 && w[24:20] == 0) oh[1] = 1;
                else if (w[19:15] == 0 && w[24:20] == 1) oh[2] = 1;
                else bad = 1;
            end else if (w[31:25] == 7'b0001011) oh[0] = 1;
            else if (!h) bad = 1;                               // R7
            else if (w[31:25] == 7'b0010011) oh[3] = 1;
            else oh[4] = 1;
        end
        usr = (p == 2'b00) || (p == 2'b10);
        sup = (p == 2'b01);
        vv  = v && h;
        if (bad) ill = 1;
        else if (oh != 0 && usr) ill = 1;                       // R8
        else if (sup && !vv) begin
            if ((oh[0] || oh[4]) && t) ill = 1;                 // R10, R11
        end else if (sup && vv) begin
            if (oh[0] && vt) vir = 1;                           // R10
            if (oh[3] || oh[4]) vir = 1;                        // R11
        end
        ref_model = {oh, ill, vir};
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] w, input logic [1:0] p, input logic v,
                         input logic t, input logic vt, input logic h, input string tag);
        logic [6:0] e;
        @(negedge clk);
        in_valid = 1; in_word = w; priv_lvl = p; virt_mode = v; tvm = t; vtvm = vt; hyp_en = h;
        e = ref_model(w, p, v, t, vt, h);
        @(posedge clk); #1;
        check("R2", "out_valid", int'(out_valid), 1);
        check(tag, "op_onehot", int'(op_onehot), int'(e[6:2]));
        check("R3", "rs1", int'(out_rs1), int'(w[19:15]));
        check("R3", "rs2", int'(out_rs2), int'(w[24:20]));
        check(tag, "exc", int'({exc_illegal, exc_virtual}), int'(e[1:0]));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 0; in_word = $urandom;
        @(posedge clk); #1;
        check("R2", "idle outputs", int'({out_valid, op_onehot, exc_illegal, exc_virtual}), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        in_valid = 1; in_word = mk(7'b0001011, 5'd3, 5'd4, 5'd0);
        repeat (3) @(posedge clk);
        #1;
        // R1: reset clears outputs even with a valid word present
        check("R1", "reset outputs",
              int'({out_valid, op_onehot, out_rs1, out_rs2, exc_illegal, exc_virtual}), 0);
        @(negedge clk); rst_n = 1; in_valid = 0;
        idle();

        // R4 each operation in machine mode (R9)
        apply(mk(7'b0001011, 5'd7, 5'd9, 0), 2'b11, 0, 1, 1, 1, "R4");
        apply(mk(7'b0001100, 5'd0, 5'd0, 0), 2'b11, 0, 1, 1, 1, "R5");
        apply(mk(7'b0001100, 5'd1, 5'd0, 0), 2'b11, 0, 1, 1, 1, "R5");
        apply(mk(7'b0010011, 5'd2, 5'd3, 0), 2'b11, 0, 1, 1, 1, "R9");
        apply(mk(7'b0110011, 5'd4, 5'd5, 0), 2'b11, 1, 1, 1, 1, "R9");
        // R4 outside the group
        apply(mk(7'b0001001, 5'd1, 5'd2, 0), 2'b01, 0, 1, 1, 1, "R4");
        apply(mk(7'b0001011, 5'd1, 5'd2, 0) ^ 32'h0000_1000, 2'b00, 0, 0, 0, 1, "R4");
        // R5 malformed fences
        apply(mk(7'b0001100, 5'd2, 5'd0, 0), 2'b11, 0, 0, 0, 1, "R5");
        apply(mk(7'b0001100, 5'd0, 5'd6, 0), 2'b11, 0, 0, 0, 1, "R5");
        // R6 rd non-zero
        apply(mk(7'b0001011, 5'd1, 5'd1, 5'd8), 2'b11, 0, 0, 0, 1, "R6");
        // R7 hypervisor disabled
        apply(mk(7'b0010011, 5'd1, 5'd1, 0), 2'b11, 0, 0, 0, 0, "R7");
        apply(mk(7'b0110011, 5'd1, 5'd1, 0), 2'b01, 1, 0, 0, 0, "R7");
        apply(mk(7'b0001011, 5'd1, 5'd1, 0), 2'b01, 1, 0, 1, 0, "R7");
        // R8 user and reserved privilege
        apply(mk(7'b0001100, 5'd0, 5'd0, 0), 2'b00, 0, 0, 0, 1, "R8");
        apply(mk(7'b0010011, 5'd0, 5'd0, 0), 2'b10, 1, 0, 0, 1, "R8");
        // R10 supervisor invalidate
        apply(mk(7'b0001011, 5'd1, 5'd1, 0), 2'b01, 0, 1, 0, 1, "R10");
        apply(mk(7'b0001011, 5'd1, 5'd1, 0), 2'b01, 0, 0, 1, 1, "R10");
        apply(mk(7'b0001011, 5'd1, 5'd1, 0), 2'b01, 1, 0, 1, 1, "R10");
        apply(mk(7'b0001011, 5'd1, 5'd1, 0), 2'b01, 1, 1, 0, 1, "R10");
        // R11 hypervisor invalidates
        apply(mk(7'b0110011, 5'd1, 5'd1, 0), 2'b01, 0, 1, 0, 1, "R11");
        apply(mk(7'b0010011, 5'd1, 5'd1, 0), 2'b01, 0, 1, 1, 1, "R11");
        apply(mk(7'b0010011, 5'd1, 5'd1, 0), 2'b01, 1, 0, 0, 1, "R11");
        apply(mk(7'b0110011, 5'd1, 5'd1, 0), 2'b01, 1, 0, 0, 1, "R11");
        // R12 fences under every trap bit
        for (int k = 0; k < 8; k++) begin
            apply(mk(7'b0001100, 5'(k & 1), 5'd0, 0), 2'b01, k[2], k[1], 1'b1, 1, "R12");
        end
        idle();

        // random phase (R13 covered through reference and checker)
        for (int i = 0; i < N_RANDOM; i++) begin
            logic [6:0] f7;
            logic [4:0] rs2, rs1, rd;
            logic [31:0] w;
            int s;
            s = $urandom_range(0, 9);
            f7 = (s < 2) ? 7'b0001011 : (s < 5) ? 7'b0001100 : (s < 7) ? 7'b0010011 :
                 (s < 9) ? 7'b0110011 : 7'($urandom);
            rs2 = ($urandom_range(0, 3) != 0) ? 5'($urandom_range(0, 1)) : 5'($urandom);
            rs1 = ($urandom_range(0, 3) != 0) ? 5'd0 : 5'($urandom);
            rd  = ($urandom_range(0, 7) != 0) ? 5'd0 : 5'($urandom);
            w = mk(f7, rs2, rs1, rd);
            if ($urandom_range(0, 15) == 0) w[14:12] = 3'($urandom);
            if ($urandom_range(0, 15) == 0) w[6:0] = 7'($urandom);
            apply(w, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom_range(0, 3) != 0), "R13");
            if ($urandom_range(0, 9) == 0) idle();
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule